// File: doc/BRIEF.md
# Slot Hotplug Event Controller

This block tracks device insertion and removal across up to 32 slots and tells software about them through a two-byte general-purpose event register pair. A hotplug source presents a one-cycle strobe with a slot number and an insert/remove flag. The block then rewrites its two slot bitmaps so that they hold only that newest event. It latches event status bit 1 and, if the matching enable bit is set, raises a one-cycle interrupt pulse.

Software uses two register ports. A byte-wide port covers the 16-bit event status and the 16-bit event enable, each split into low and high byte lanes. A word-wide port covers the insert bitmap, the remove bitmap and an eject register. Writing the eject register issues a one-cycle eject request naming the lowest set slot in the written value. The device teardown itself happens outside this block.

Top module: `hp_event_ctrl`

## Requirements
- R1: After reset, status, enable and both bitmaps read 0, and irq_o and eject_valid_o are low.
- R2: Event-port offsets 0 and 1 are the status low and high bytes. A write there clears each status bit whose written bit is 1, in that lane only, and leaves the other lane unchanged.
- R3: Event-port offsets 2 and 3 are the enable low and high bytes. A write replaces only the addressed byte, and reads return the stored value.
- R4: Slot-port byte offset 0 is the insert bitmap and offset 4 is the remove bitmap. Both are 32 bits wide, read back what was written, and can be overwritten by software.
- R5: An event (hp_valid_i high for one cycle) clears both bitmaps. It then sets bit hp_slot_i in the insert bitmap when hp_insert_i=1, or in the remove bitmap when hp_insert_i=0. It also sets status bit 1.
- R6: If enable bit 1 is set in the cycle of an event, irq_o is high for exactly the next cycle and then low. If enable bit 1 is clear, irq_o stays low.
- R7: A write to slot-port offset 8 with a nonzero value makes eject_valid_o high for exactly the next cycle. In that cycle, eject_slot_o holds the index of the lowest set bit of the written value.
- R8: A write of zero to offset 8 produces no eject request, and reads of offset 8 return 0.
- R9: Slot-port offsets other than 0, 4 and 8 read 0, and writes to them change no register.
- R10: If an event and a status write that clears bit 1 happen in the same cycle, status bit 1 ends up set.
- R11: If an event and a software bitmap write happen in the same cycle, the event's result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_req_i | input | 1 | Event-port access strobe |
| ev_we_i | input | 1 | Event-port write (1) or read (0) |
| ev_addr_i | input | 2 | Event-port byte offset |
| ev_wdata_i | input | 8 | Event-port write byte |
| ev_rdata_o | output | 8 | Event-port read byte (combinational) |
| sl_req_i | input | 1 | Slot-port access strobe |
| sl_we_i | input | 1 | Slot-port write (1) or read (0) |
| sl_addr_i | input | 4 | Slot-port byte offset |
| sl_wdata_i | input | 32 | Slot-port write word |
| sl_rdata_o | output | 32 | Slot-port read word (combinational) |
| hp_valid_i | input | 1 | Hotplug event strobe |
| hp_slot_i | input | 5 | Slot of the event |
| hp_insert_i | input | 1 | 1 for insertion, 0 for removal |
| irq_o | output | 1 | One-cycle interrupt pulse |
| eject_valid_o | output | 1 | One-cycle eject request |
| eject_slot_o | output | 5 | Slot to eject |

## Verification
Register writes and events take effect at the clock edge that samples them, and read data is combinational, so a read taken in the following low phase shows the new value. irq_o and the eject request are registered, so each is due in the cycle right after its stimulus and must be gone one cycle later. The bench drives inputs on falling edges and samples outputs on the next falling edge and the one after it, which checks both the rising edge and the return to low of every pulse.

// File: rtl/hp_event_pkg.sv
package hp_event_pkg;
  parameter int unsigned SLOTS     = 32;
  parameter int unsigned GPE_BYTES = 2;
  parameter int unsigned HP_BIT    = 1;
  parameter int unsigned SL_AW     = 4;
  localparam int unsigned SLOT_W   = $clog2(SLOTS);
  localparam int unsigned GPE_W    = 8 * GPE_BYTES;
  localparam int unsigned EV_AW    = $clog2(2 * GPE_BYTES);
  localparam logic [SL_AW-1:0] OFF_INS = 4'h0;
  localparam logic [SL_AW-1:0] OFF_REM = 4'h4;
  localparam logic [SL_AW-1:0] OFF_EJ  = 4'h8;
endpackage

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs
  import hp_event_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [EV_AW-1:0] addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             set_evt_i,
  output logic [GPE_W-1:0] status_o,
  output logic [GPE_W-1:0] enable_o
);
  for (genvar l = 0; l < GPE_BYTES; l++) begin : g_lane
    localparam logic [EV_AW-1:0] STS_OFF = EV_AW'(l);
    localparam logic [EV_AW-1:0] EN_OFF  = EV_AW'(GPE_BYTES + l);
    logic [7:0] sts_q, en_q, sts_d, set_m;

    always_comb begin
      set_m = '0;
      if (set_evt_i && (HP_BIT / 8 == l)) set_m[HP_BIT % 8] = 1'b1;
      sts_d = sts_q;
      if (wr_i && addr_i == STS_OFF) sts_d = sts_q & ~wdata_i;
      sts_d = sts_d | set_m;  // event set beats W1C
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_q <= '0;
        en_q  <= '0;
      end else begin
        sts_q <= sts_d;
        if (wr_i && addr_i == EN_OFF) en_q <= wdata_i;
      end
    end

    assign status_o[8*l +: 8] = sts_q;
    assign enable_o[8*l +: 8] = en_q;
  end
endmodule

// File: rtl/hp_slot_maps.sv
module hp_slot_maps
  import hp_event_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ins_i,
  input  logic              wr_rem_i,
  input  logic [SLOTS-1:0]  wdata_i,
  input  logic              hp_valid_i,
  input  logic [SLOT_W-1:0] hp_slot_i,
  input  logic              hp_insert_i,
  output logic [SLOTS-1:0]  ins_o,
  output logic [SLOTS-1:0]  rem_o
);
  logic [SLOTS-1:0] ins_q, rem_q, onehot;

  assign onehot = SLOTS'(1) << hp_slot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q <= '0;
      rem_q <= '0;
    end else if (hp_valid_i) begin
      ins_q <= hp_insert_i ? onehot : '0;
      rem_q <= hp_insert_i ? '0 : onehot;
    end else begin
      if (wr_ins_i) ins_q <= wdata_i;
      if (wr_rem_i) rem_q <= wdata_i;
    end
  end

  assign ins_o = ins_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/hp_eject_enc.sv
module hp_eject_enc
  import hp_event_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SLOTS-1:0]  wdata_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [SLOT_W-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (wdata_i[i]) low_idx = SLOT_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      slot_o  <= '0;
    end else begin
      valid_o <= wr_i && (wdata_i != '0);
      if (wr_i) slot_o <= low_idx;
    end
  end
endmodule

// File: rtl/hp_event_ctrl.sv
module hp_event_ctrl
  import hp_event_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_req_i,
  input  logic              ev_we_i,
  input  logic [EV_AW-1:0]  ev_addr_i,
  input  logic [7:0]        ev_wdata_i,
  output logic [7:0]        ev_rdata_o,
  input  logic              sl_req_i,
  input  logic              sl_we_i,
  input  logic [SL_AW-1:0]  sl_addr_i,
  input  logic [SLOTS-1:0]  sl_wdata_i,
  output logic [SLOTS-1:0]  sl_rdata_o,
  input  logic              hp_valid_i,
  input  logic [SLOT_W-1:0] hp_slot_i,
  input  logic              hp_insert_i,
  output logic              irq_o,
  output logic              eject_valid_o,
  output logic [SLOT_W-1:0] eject_slot_o
);
  logic [GPE_W-1:0] status, enable;
  logic [SLOTS-1:0] ins_map, rem_map;
  logic             sl_wr, irq_q;
  logic [2*GPE_W-1:0] ev_file;

  assign sl_wr = sl_req_i && sl_we_i;

  hp_gpe_regs u_gpe (
    .clk_i, .rst_ni,
    .wr_i      (ev_req_i && ev_we_i),
    .addr_i    (ev_addr_i),
    .wdata_i   (ev_wdata_i),
    .set_evt_i (hp_valid_i),
    .status_o  (status),
    .enable_o  (enable)
  );

  hp_slot_maps u_maps (
    .clk_i, .rst_ni,
    .wr_ins_i    (sl_wr && sl_addr_i == OFF_INS),
    .wr_rem_i    (sl_wr && sl_addr_i == OFF_REM),
    .wdata_i     (sl_wdata_i),
    .hp_valid_i,
    .hp_slot_i,
    .hp_insert_i,
    .ins_o       (ins_map),
    .rem_o       (rem_map)
  );

  hp_eject_enc u_ej (
    .clk_i, .rst_ni,
    .wr_i    (sl_wr && sl_addr_i == OFF_EJ),
    .wdata_i (sl_wdata_i),
    .valid_o (eject_valid_o),
    .slot_o  (eject_slot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= hp_valid_i && enable[HP_BIT];
  end
  assign irq_o = irq_q;

  assign ev_file    = {enable, status};
  assign ev_rdata_o = ev_file[8*ev_addr_i +: 8];

  always_comb begin
    unique case (sl_addr_i)
      OFF_INS: sl_rdata_o = ins_map;
      OFF_REM: sl_rdata_o = rem_map;
      default: sl_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/hp_event_ctrl_chk.sv
module hp_event_ctrl_chk
  import hp_event_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hp_valid_i,
  input logic              sl_req_i,
  input logic              sl_we_i,
  input logic [SL_AW-1:0]  sl_addr_i,
  input logic [SLOTS-1:0]  sl_wdata_i,
  input logic [GPE_W-1:0]  status,
  input logic [GPE_W-1:0]  enable,
  input logic [SLOTS-1:0]  ins_map,
  input logic [SLOTS-1:0]  rem_map,
  input logic              irq_o,
  input logic              eject_valid_o,
  input logic [SLOT_W-1:0] eject_slot_o
);
  logic [SLOTS-1:0] wd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wd_q <= '0;
    else         wd_q <= sl_wdata_i;
  end

  // R5 R10
  evt_sets_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_valid_i |=> status[HP_BIT]);

  // R5
  evt_single_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_valid_i |=> ($countones(ins_map | rem_map) == 1));

  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(hp_valid_i && enable[HP_BIT]));

  // R6
  irq_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_valid_i && enable[HP_BIT]) |=> irq_o);

  // R7 R8
  eject_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_valid_o |-> $past(sl_req_i && sl_we_i && sl_addr_i == OFF_EJ && sl_wdata_i != '0));

  // R7
  eject_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_valid_o |-> (wd_q[eject_slot_o] && ((wd_q & ((SLOTS'(1) << eject_slot_o) - SLOTS'(1))) == '0)));
endmodule

bind hp_event_ctrl hp_event_ctrl_chk u_chk (
  .clk_i, .rst_ni, .hp_valid_i, .sl_req_i, .sl_we_i, .sl_addr_i, .sl_wdata_i,
  .status, .enable, .ins_map, .rem_map, .irq_o, .eject_valid_o, .eject_slot_o
);

// File: tb/hp_event_ctrl_tb_top.sv
module hp_event_ctrl_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ev_req_i = 0, ev_we_i = 0;
  logic [1:0]  ev_addr_i = 0;
  logic [7:0]  ev_wdata_i = 0, ev_rdata_o;
  logic        sl_req_i = 0, sl_we_i = 0;
  logic [3:0]  sl_addr_i = 0;
  logic [31:0] sl_wdata_i = 0, sl_rdata_o;
  logic        hp_valid_i = 0, hp_insert_i = 0;
  logic [4:0]  hp_slot_i = 0;
  logic        irq_o, eject_valid_o;
  logic [4:0]  eject_slot_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  hp_event_ctrl dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ev_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i); ev_req_i = 1; ev_we_i = 1; ev_addr_i = a; ev_wdata_i = d;
    @(negedge clk_i); ev_req_i = 0; ev_we_i = 0;
  endtask

  task automatic ev_rd(logic [1:0] a, output logic [7:0] d);
    ev_addr_i = a; #1 d = ev_rdata_o;
  endtask

  task automatic sl_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i); sl_req_i = 1; sl_we_i = 1; sl_addr_i = a; sl_wdata_i = d;
    @(negedge clk_i); sl_req_i = 0; sl_we_i = 0;
  endtask

  task automatic sl_rd(logic [3:0] a, output logic [31:0] d);
    sl_addr_i = a; #1 d = sl_rdata_o;
  endtask

  task automatic hp_event(logic [4:0] s, logic ins, logic exp_irq);
    @(negedge clk_i); hp_valid_i = 1; hp_slot_i = s; hp_insert_i = ins;
    @(negedge clk_i); hp_valid_i = 0;
    check("R6 irq due", irq_o, exp_irq);
    @(negedge clk_i);
    check("R6 irq low after", irq_o, 0);
  endtask

  function automatic logic [4:0] lowest(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 0;
  endfunction

  task automatic t_reset();
    logic [7:0] b; logic [31:0] w;
    for (int a = 0; a < 4; a++) begin ev_rd(2'(a), b); check("R1 event reg", b, 0); end
    sl_rd(4'h0, w); check("R1 insert map", w, 0);
    sl_rd(4'h4, w); check("R1 remove map", w, 0);
    check("R1 irq", irq_o, 0);
    check("R1 eject", eject_valid_o, 0);
  endtask

  task automatic t_enable();
    logic [7:0] b;
    ev_wr(2, 8'hA5); ev_wr(3, 8'h3C);
    ev_rd(2, b); check("R3 en low", b, 8'hA5);
    ev_rd(3, b); check("R3 en high", b, 8'h3C);
    ev_wr(2, 8'h00);
    ev_rd(2, b); check("R3 en low rewrite", b, 8'h00);
    ev_rd(3, b); check("R3 en high kept", b, 8'h3C);
  endtask

  task automatic t_event_irq();
    logic [31:0] w; logic [7:0] b;
    hp_event(5'd7, 1'b1, 1'b0);  // enable bit 1 clear
    sl_rd(4'h0, w); check("R5 insert bit 7", w, 32'h80);
    sl_rd(4'h4, w); check("R5 remove empty", w, 0);
    ev_rd(0, b); check("R5 status bit1", b, 8'h02);
    ev_wr(2, 8'h02);
    sl_wr(4'h4, 32'hFFFF_0000);
    hp_event(5'd31, 1'b0, 1'b1);
    sl_rd(4'h0, w); check("R5 insert wiped", w, 0);
    sl_rd(4'h4, w); check("R5 remove bit 31", w, 32'h8000_0000);
  endtask

  task automatic t_status_w1c();
    logic [7:0] b;
    ev_wr(1, 8'hFF);
    ev_rd(0, b); check("R2 low lane untouched", b, 8'h02);
    ev_wr(0, 8'h01);
    ev_rd(0, b); check("R2 zero bit kept", b, 8'h02);
    ev_wr(0, 8'h02);
    ev_rd(0, b); check("R2 bit1 cleared", b, 8'h00);
  endtask

  task automatic t_bitmaps();
    logic [31:0] w;
    sl_wr(4'h0, 32'hDEAD_BEEF); sl_wr(4'h4, 32'h1234_5678);
    sl_rd(4'h0, w); check("R4 insert rw", w, 32'hDEAD_BEEF);
    sl_rd(4'h4, w); check("R4 remove rw", w, 32'h1234_5678);
    sl_wr(4'hC, 32'hFFFF_FFFF);
    sl_rd(4'hC, w); check("R9 unmapped read", w, 0);
    sl_rd(4'h0, w); check("R9 insert unchanged", w, 32'hDEAD_BEEF);
    sl_rd(4'h4, w); check("R9 remove unchanged", w, 32'h1234_5678);
    check("R9 no eject", eject_valid_o, 0);
  endtask

  task automatic t_eject(logic [31:0] v);
    @(negedge clk_i); sl_req_i = 1; sl_we_i = 1; sl_addr_i = 4'h8; sl_wdata_i = v;
    @(negedge clk_i); sl_req_i = 0; sl_we_i = 0;
    if (v != 0) begin
      check("R7 eject valid", eject_valid_o, 1);
      check("R7 eject slot", eject_slot_o, lowest(v));
    end else check("R8 zero no eject", eject_valid_o, 0);
    @(negedge clk_i);
    check("R7 eject one cycle", eject_valid_o, 0);
  endtask

  task automatic t_collide();
    logic [7:0] b; logic [31:0] w;
    @(negedge clk_i);
    hp_valid_i = 1; hp_slot_i = 5'd3; hp_insert_i = 1;
    ev_req_i = 1; ev_we_i = 1; ev_addr_i = 0; ev_wdata_i = 8'hFF;
    sl_req_i = 1; sl_we_i = 1; sl_addr_i = 4'h0; sl_wdata_i = 32'h5555_0000;
    @(negedge clk_i);
    hp_valid_i = 0; ev_req_i = 0; ev_we_i = 0; sl_req_i = 0; sl_we_i = 0;
    check("R6 irq on collide", irq_o, 1);
    ev_rd(0, b); check("R10 set wins", b, 8'h02);
    sl_rd(4'h0, w); check("R11 event wins", w, 32'h8);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_enable();
    t_event_irq();
    t_status_w1c();
    t_bitmaps();
    t_eject(32'h0000_0100);
    t_eject(32'h8000_0000);
    t_eject(32'hF0F0_0006);
    t_eject(32'h0000_0001);
    t_eject(32'h0);
    sl_rd(4'h8, w); check("R8 eject reads 0", w, 0);
    t_collide();
    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule